// File: doc/BRIEF.md
# Multi-Chassis Sync Trigger with Skew Counter

This block lines up the converter start of one front-end board with the boards in other chassis. It works in two phases that share one clock, the reference clock. In the measurement phase a cycle counter runs from a start event until the shared return beacon is seen on a rising edge. The start event is the local beacon transmit strobe on the chassis that sends the beacon, and the received sync pulse on every other chassis. The count is held on the outputs for a supervisor, which subtracts counts across chassis to obtain each chassis's delay correction. For example, a reference count of 16 against a follower count of 13 gives the reference a delay of 3 cycles.

In the trigger phase a start command is accepted first. The next rising edge of the sync pulse then starts a countdown of the programmed delay in reference-clock cycles, and the converter trigger is driven from a falling-edge register. With the delays applied, chassis stay aligned to within one reference-clock period, about 16 ns at 61.44 MHz. Both asynchronous inputs pass through a two-stage synchronizer and a rising-edge detector. A timeout bounds the measurement when no beacon arrives.

Top module: `chassis_sync_trigger`

## Requirements
- R1: `sync_in` and `beacon_in` are each synchronized by two flops and acted on only at a low-to-high transition. A level held high produces one event, and a new event needs the input to go low and high again.
- R2: With `ref_mode`=1, counting starts at the rising edge that samples `beacon_tx` high, and `sync_in` does not start it. If `beacon_in` is first sampled high g edges after that edge, `skew_count` ends at g+2 and `skew_done` rises.
- R3: With `ref_mode`=0, counting starts on a `sync_in` event, and `beacon_tx` is ignored. If `beacon_in` is first sampled high g≥1 edges after `sync_in` was first sampled high, `skew_count` ends at g.
- R4: If no beacon event arrives before the count reaches `timeout_cycles`, the count stops at `timeout_cycles` and both `skew_ovf` and `skew_done` are set. A beacon event on the same edge at which the count reaches the limit wins, and no overflow is flagged.
- R5: `skew_count`, `skew_done` and `skew_ovf` hold their values until the next `meas_arm` pulse. That pulse clears all three to 0 on the following edge.
- R6: `conv_trig` fires only after a `start_cmd` has been accepted and a `sync_in` event has followed it. A sync event with no pending command produces no trigger.
- R7: Let S be the rising edge that detects the sync event and d the value of `delay_cycles`. `conv_trig` goes high at the falling edge that follows rising edge S+d, stays high for one clock period, and is registered on the falling edge.
- R8: `trig_pending` is 1 from command acceptance until the trigger fires. A `start_cmd` that arrives while it is 1 is ignored, so no second trigger results from it.
- R9: While `rst_n` is low, all outputs are 0 at the next edge.
- R10: A beacon event that arrives at or before the start event is ignored, and the measurement then runs on to the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_mode | input | 1 | 1 = this chassis transmits the beacon |
| meas_arm | input | 1 | One-cycle pulse that clears the result and arms a measurement |
| beacon_tx | input | 1 | Synchronous strobe marking local beacon transmission |
| sync_in | input | 1 | Asynchronous sync pulse from the chassis hub |
| beacon_in | input | 1 | Asynchronous received beacon |
| timeout_cycles | input | CNT_W | Count limit for one measurement |
| skew_count | output | CNT_W | Measured cycle count |
| skew_done | output | 1 | Measurement finished |
| skew_ovf | output | 1 | Measurement stopped by timeout |
| start_cmd | input | 1 | One-cycle start command |
| delay_cycles | input | OFS_W | Trigger delay in reference-clock cycles |
| trig_pending | output | 1 | Command accepted, trigger not yet issued |
| conv_trig | output | 1 | Converter trigger, one cycle, falling-edge registered |

## Verification
The measurement is driven from a vector table that covers both start sources, several beacon gaps, a beacon that lands exactly on the timeout edge, gaps longer than the timeout, and a beacon that coincides with the start. Together these separate an off-by-one in the count from a wrong start source and from a wrong choice between beacon and timeout. The trigger is tried with zero and non-zero delays, sampling both half periods to show it rises on the falling edge. Further patterns cover a sync with no command, a second command during the delay, and a command issued while sync stays high. These show that only a fresh edge after an accepted command fires the trigger.

// File: rtl/sync_trig_pkg.sv
// Shared state encodings for the multi-chassis sync trigger.
package sync_trig_pkg;
    typedef enum logic [1:0] {M_IDLE, M_WAIT, M_COUNT, M_DONE} meas_st_e;
    typedef enum logic [1:0] {T_IDLE, T_WAIT, T_DELAY} trig_st_e;
endpackage

// File: rtl/sts_edge_sync.sv
// Synchronizes one asynchronous input and flags its rising edge.
// Assumes the input stays high or low for at least one clock period.
module sts_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    // Shift register: STAGES synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[LAST-1:0], din};
    end

    assign rise = sh[LAST-1] & ~sh[LAST];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R1
endmodule

// File: rtl/sts_skew_meter.sv
// Counts reference-clock cycles from a start event to the beacon event.
// Holds the result until re-armed; saturates at the timeout limit.
module sts_skew_meter
    import sync_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             ref_mode,
    input  logic             tx_strobe,
    input  logic             sync_rise,
    input  logic             beacon_rise,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    meas_st_e         st;
    logic             start;
    logic [CNT_W-1:0] nxt;

    // Start source depends on whether this chassis sends the beacon.
    assign start = ref_mode ? tx_strobe : sync_rise;
    assign nxt   = count + ONE;

    // Measurement state machine and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= M_IDLE; count <= '0; done <= 1'b0; ovf <= 1'b0;
        end else if (arm) begin
            st <= M_WAIT; count <= '0; done <= 1'b0; ovf <= 1'b0;
        end else begin
            case (st)
                M_WAIT: if (start) begin
                    st <= M_COUNT; count <= '0;
                end
                M_COUNT: if (beacon_rise) begin
                    count <= nxt; done <= 1'b1; st <= M_DONE;
                end else if (nxt >= limit) begin
                    count <= limit; ovf <= 1'b1; done <= 1'b1; st <= M_DONE;
                end else begin
                    count <= nxt;
                end
                default: ;
            endcase
        end
    end

    AST_OVF_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> done); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> (done && $stable(count))); // R5
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!done && !ovf && count == '0)); // R5
endmodule

// File: rtl/sts_trig_sched.sv
// Accepts a start command, waits for a sync edge, counts the programmed
// delay and issues a one-cycle trigger from a falling-edge register.
module sts_trig_sched
    import sync_trig_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd,
    input  logic             sync_rise,
    input  logic [OFS_W-1:0] offset,
    output logic             fire,
    output logic             pending,
    output logic             trig
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    trig_st_e         st;
    logic [OFS_W-1:0] dcnt;

    assign pending = (st != T_IDLE);

    // Command / sync / delay sequencing; fire is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= T_IDLE; dcnt <= '0; fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            case (st)
                T_IDLE: if (cmd) st <= T_WAIT;
                T_WAIT: if (sync_rise) begin
                    if (offset == '0) begin
                        fire <= 1'b1; st <= T_IDLE;
                    end else begin
                        dcnt <= offset; st <= T_DELAY;
                    end
                end
                T_DELAY: if (dcnt == ONE) begin
                    fire <= 1'b1; st <= T_IDLE;
                end else begin
                    dcnt <= dcnt - ONE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    // Falling-edge output register for the converter trigger.
    always_ff @(negedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= fire;
    end

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R7
    AST_PENDING_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(cmd)); // R6
    AST_FIRE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(pending)); // R6
    AST_FIRE_ENDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !pending); // R8
endmodule

// File: rtl/chassis_sync_trigger.sv
// Top level: synchronizes sync and beacon inputs, measures inter-chassis
// skew in cycles and schedules the delayed converter trigger.
// Assumes clk is the reference clock shared by the measurement and trigger.
module chassis_sync_trigger #(
    parameter int CNT_W = 16,
    parameter int OFS_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_mode,
    input  logic             meas_arm,
    input  logic             beacon_tx,
    input  logic             sync_in,
    input  logic             beacon_in,
    input  logic [CNT_W-1:0] timeout_cycles,
    output logic [CNT_W-1:0] skew_count,
    output logic             skew_done,
    output logic             skew_ovf,
    input  logic             start_cmd,
    input  logic [OFS_W-1:0] delay_cycles,
    output logic             trig_pending,
    output logic             conv_trig
);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_in;
    logic [N_ASYNC-1:0] async_rise;
    logic               fire;

    assign async_in = {beacon_in, sync_in};

    // One synchronizer and edge detector per asynchronous input.
    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        sts_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (async_in[g]),
            .rise (async_rise[g])
        );
    end

    sts_skew_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (meas_arm),
        .ref_mode   (ref_mode),
        .tx_strobe  (beacon_tx),
        .sync_rise  (async_rise[0]),
        .beacon_rise(async_rise[1]),
        .limit      (timeout_cycles),
        .count      (skew_count),
        .done       (skew_done),
        .ovf        (skew_ovf)
    );

    sts_trig_sched #(.OFS_W(OFS_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (start_cmd),
        .sync_rise(async_rise[0]),
        .offset   (delay_cycles),
        .fire     (fire),
        .pending  (trig_pending),
        .trig     (conv_trig)
    );

    AST_TRIG_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_trig) |-> fire); // R7
endmodule

// File: tb/chassis_sync_trigger_tb.sv
module chassis_sync_trigger_tb;
    localparam int CW = 16;
    localparam int OW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, ref_mode = 1'b0, meas_arm = 1'b0, beacon_tx = 1'b0;
    logic sync_in = 1'b0, beacon_in = 1'b0, start_cmd = 1'b0;
    logic [CW-1:0] timeout_cycles = '0;
    logic [OW-1:0] delay_cycles = '0;
    logic [CW-1:0] skew_count;
    logic skew_done, skew_ovf, trig_pending, conv_trig;

    chassis_sync_trigger #(.CNT_W(CW), .OFS_W(OW)) u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {ref_mode, gap, timeout, expected count, expected overflow}
    localparam int NV = 7;
    localparam int VEC [NV][5] = '{
        '{0,  5, 20,  5, 0},   // R3 basic follower
        '{0,  1, 20,  1, 0},   // R3 minimum gap
        '{1,  4, 20,  6, 0},   // R2 reference, +2 synchronizer bias
        '{0, 12, 12, 12, 0},   // R4 beacon on the limit edge wins
        '{0, 15, 10, 10, 1},   // R4 timeout
        '{1,  0,  2,  2, 0},   // R2 reference, beacon immediate
        '{0,  0,  8,  8, 1}    // R10 beacon together with start ignored
    };

    task automatic run_meas(int isref, int gap, int tmo, int ec, int eov);
        string tag;
        tag = eov ? "R4" : (isref ? "R2" : "R3");
        if (!isref && gap == 0) tag = "R10";
        @(negedge clk);
        ref_mode = isref[0]; timeout_cycles = CW'(tmo); meas_arm = 1'b1;
        @(negedge clk);
        meas_arm = 1'b0;
        repeat (2) @(negedge clk);
        if (isref != 0) beacon_tx = 1'b1; else sync_in = 1'b1;
        beacon_in = (gap == 0);
        @(negedge clk);
        beacon_tx = 1'b0;
        for (int i = 1; i < gap; i++) @(negedge clk);
        if (gap > 0) beacon_in = 1'b1;
        for (int w = 0; w < tmo + 12 && !skew_done; w++) @(negedge clk);
        check({tag, " done"}, int'(skew_done), 1);
        check({tag, " count"}, int'(skew_count), ec);
        check({tag, " ovf"}, int'(skew_ovf), eov);
        sync_in = 1'b0; beacon_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watch n cycles, sampling just after each rising and each falling edge.
    task automatic watch(int n, output int first, output int hi);
        first = -1; hi = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); #2;
            if (conv_trig) begin if (first < 0) first = 2 * i; hi++; end
            #4;
            if (conv_trig) begin if (first < 0) first = 2 * i + 1; hi++; end
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk); start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
    endtask

    task automatic run_trig(int d);
        int first, hi;
        delay_cycles = OW'(d);
        pulse_cmd();
        check("R8 pending after cmd", int'(trig_pending), 1);
        sync_in = 1'b1;
        watch(d + 8, first, hi);
        check("R7 trigger half-slot", first, 2 * (d + 3) + 1);
        check("R7 trigger width", hi, 2);
        @(negedge clk); sync_in = 1'b0;
        check("R8 pending cleared", int'(trig_pending), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int first, hi, held;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 count", int'(skew_count), 0);
        check("R9 done", int'(skew_done), 0);
        check("R9 ovf", int'(skew_ovf), 0);
        check("R9 pending", int'(trig_pending), 0);
        check("R9 trig", int'(conv_trig), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_meas(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

        // R5 result held: extra events without re-arming change nothing
        held = int'(skew_count);
        @(negedge clk); sync_in = 1'b1;
        repeat (3) @(negedge clk); beacon_in = 1'b1;
        repeat (6) @(negedge clk); sync_in = 1'b0; beacon_in = 1'b0;
        check("R5 count held", int'(skew_count), held);
        check("R5 done held", int'(skew_done), 1);
        @(negedge clk); meas_arm = 1'b1;
        @(negedge clk); meas_arm = 1'b0;
        check("R5 arm clears done", int'(skew_done), 0);
        check("R5 arm clears count", int'(skew_count), 0);
        check("R5 arm clears ovf", int'(skew_ovf), 0);

        // R3 follower mode ignores the transmit strobe as a start
        ref_mode = 1'b0; timeout_cycles = CW'(30);
        @(negedge clk); beacon_tx = 1'b1;
        @(negedge clk); beacon_tx = 1'b0;
        repeat (2) @(negedge clk); beacon_in = 1'b1;
        repeat (6) @(negedge clk); beacon_in = 1'b0;
        check("R3 strobe ignored in follower mode", int'(skew_done), 0);
        meas_arm = 1'b1; @(negedge clk); meas_arm = 1'b0;

        // R6 sync without command: no trigger
        @(negedge clk); sync_in = 1'b1;
        watch(10, first, hi);
        check("R6 no trigger without cmd", hi, 0);
        @(negedge clk); sync_in = 1'b0;
        repeat (3) @(negedge clk);

        run_trig(0);
        run_trig(3);
        run_trig(5);

        // R8 second command during the delay is ignored
        delay_cycles = OW'(6);
        pulse_cmd();
        sync_in = 1'b1;
        repeat (4) @(negedge clk);
        start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
        watch(12, first, hi);
        check("R8 single trigger", hi, 2);
        check("R8 pending after fire", int'(trig_pending), 0);
        @(negedge clk); sync_in = 1'b0;
        repeat (3) @(negedge clk); sync_in = 1'b1;
        watch(10, first, hi);
        check("R8 ignored cmd gives no trigger", hi, 0);

        // R1 command while sync held high: needs a fresh edge
        delay_cycles = OW'(0);
        pulse_cmd();
        watch(8, first, hi);
        check("R1 held level no trigger", hi, 0);
        check("R1 still pending", int'(trig_pending), 1);
        @(negedge clk); sync_in = 1'b0;
        repeat (3) @(negedge clk); sync_in = 1'b1;
        watch(8, first, hi);
        check("R1 fresh edge triggers", first, 2 * 3 + 1);
        @(negedge clk); sync_in = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule